// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a memory-mapped watchdog for a large chip. Software programs a count value through a simple 32-bit register port, with address, write strobe, write data and combinational read data. A fixed prescaler slows the count, and a down-counter runs from the programmed value. When the counter runs out for the first time, it raises an interrupt and starts again from the same value. If the interrupt is still pending when the counter runs out a second time, the block drives a sticky system reset.

Software keeps the system alive by writing to the service register. That write drops the interrupt and restarts the count from the full value. A key register protects all other registers: only one exact 32-bit key opens them, and any other value written there closes them again. Programming a count of zero gives the shortest possible interval, so software can force a reset on purpose.

Top module: `guard_timer`

## Requirements
- R1: The block leaves reset unlocked. Writing 0x1ACCE551 to the key register at offset 0xC00 unlocks it. Writing any other value to that offset locks it. Reading offset 0xC00 returns 1 when locked and 0 when unlocked.
- R2: Offset 0x000 reads back the programmed count value. Offset 0x008 reads back the mode bits in [1:0], with bit 0 = run and bit 1 = reset enable, and all other bits read as zero. An unmapped offset reads zero.
- R3: While the block is locked, writes to offsets 0x000, 0x008 and 0x00C change nothing.
- R4: With the run bit set, the counter steps down once every 16 clock cycles. The first expiry raises the interrupt exactly 16*(L+1) cycles after the reload edge, where L is the count value. A write to offset 0x000 is a reload edge and also restarts the prescaler.
- R5: If the interrupt is still pending at the next expiry, 16*(L+1) cycles later, and the reset-enable bit is set, the reset output rises. If the reset-enable bit is clear, the reset output does not rise.
- R6: Any write to the service offset 0x00C, whatever its data, clears the pending interrupt and reloads the count. The next expiry then comes a full 16*(L+1) cycles later.
- R7: If a service write and an expiry fall in the same cycle, the service write wins: the interrupt ends cleared and the reset output stays low.
- R8: Once the reset output is high, it stays high until the block's reset input is asserted.
- R9: Writing 0 to the mode register stops the count and holds the interrupt output low.
- R10: While reset is asserted and just after it is released, the interrupt and reset outputs are low, the mode register is 0 and the count register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Watchdog interrupt, high while pending and the run bit is set |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
The sharpest case is a service write that lands on the same clock edge as the second expiry. At that edge the reset-raising path and the clear-and-reload path both want the same flops. The bench sets a count of zero, counts 31 cycles from the reload edge, and times the service-register write so that it is sampled exactly at edge 32. It then expects the interrupt to be clear and the reset output low. It also expects a fresh interrupt 16 cycles later, which shows that the reload took effect and the expiry was dropped.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int unsigned OFS_COUNT = 32'h000;
  localparam int unsigned OFS_MODE  = 32'h008;
  localparam int unsigned OFS_SERV  = 32'h00C;
  localparam int unsigned OFS_KEY   = 32'hC00;
  localparam logic [31:0] OPEN_KEY  = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_en;
    logic run;
  } mode_t;
endpackage

// File: rtl/gt_rst_sync.sv
module gt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/gt_regs.sv
module gt_regs
  import gt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output mode_t             mode_o,
  output logic [DATA_W-1:0] reload_val_o,
  output logic              reload_o,
  output logic              serv_o
);
  logic              locked_q, locked_d, key_en;
  logic [DATA_W-1:0] count_q;
  mode_t             mode_q, mode_d;
  logic              count_en, mode_en;

  always_comb begin
    key_en   = we && (addr == ADDR_W'(OFS_KEY));
    count_en = we && !locked_q && (addr == ADDR_W'(OFS_COUNT));
    mode_en  = we && !locked_q && (addr == ADDR_W'(OFS_MODE));
    serv_o   = we && !locked_q && (addr == ADDR_W'(OFS_SERV));
    locked_d = (wdata != DATA_W'(OPEN_KEY));
    mode_d   = mode_t'(wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      count_q  <= '0;
      mode_q   <= '0;
    end else begin
      if (key_en)   locked_q <= locked_d;
      if (count_en) count_q  <= wdata;
      if (mode_en)  mode_q   <= mode_d;
    end
  end

  assign mode_o       = mode_q;
  assign reload_o     = count_en || serv_o;
  assign reload_val_o = count_en ? wdata : count_q;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_COUNT))     rdata = count_q;
    else if (addr == ADDR_W'(OFS_MODE)) rdata = {{(DATA_W-2){1'b0}}, mode_q};
    else if (addr == ADDR_W'(OFS_KEY))  rdata = {{(DATA_W-1){1'b0}}, locked_q};
  end

  // R3: a locked block keeps its count value across a write attempt
  p_locked_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && we && addr == ADDR_W'(OFS_COUNT)) |=> $stable(count_q));
  // R3: a locked block keeps its mode across a write attempt
  p_locked_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && we && addr == ADDR_W'(OFS_MODE)) |=> $stable(mode_q));
endmodule

// File: rtl/gt_prescale.sv
module gt_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick = en && (cnt_q == PW'(DIV - 1));

  always_comb begin
    cnt_en = clr || en;
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: count steps are never back to back
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/gt_countdown.sv
module gt_countdown
  import gt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic              tick,
  input  logic              reload,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              serv,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              irq_q, irq_d, srst_q, srst_d;
  logic              expire, cnt_en;

  always_comb begin
    expire = mode.run && tick && (cnt_q == '0) && !reload;
    cnt_en = reload || (mode.run && tick);
    if (reload || expire) cnt_d = reload_val;
    else                  cnt_d = cnt_q - 1'b1;
    irq_d  = serv ? 1'b0 : (expire ? 1'b1 : irq_q);
    srst_d = srst_q || (expire && irq_q && mode.rst_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      irq_q  <= irq_d;
      srst_q <= srst_d;
    end
  end

  assign irq_o     = irq_q && mode.run;
  assign sys_rst_o = srst_q;

  // R8: the reset request only ends through the reset input
  p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> srst_q);
  // R5: reset rises only from a pending interrupt with reset enabled
  p_rst_needs_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_q) |-> $past(irq_q && mode.rst_en));
  // R7: a service write leaves no interrupt, even on an expiry cycle
  p_serv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    serv |=> !irq_q);
  // R7: a service write never lets the reset request rise
  p_serv_no_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    serv |=> !$rose(srst_q));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PRESCALE  = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic              rst_sync_n, reload, serv, tick;
  logic [DATA_W-1:0] reload_val;
  mode_t             mode;

  gt_rst_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  gt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .rdata(bus_rdata), .mode_o(mode),
    .reload_val_o(reload_val), .reload_o(reload), .serv_o(serv)
  );

  gt_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .en(mode.run), .clr(reload), .tick(tick)
  );

  gt_countdown #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .mode(mode), .tick(tick),
    .reload(reload), .reload_val(reload_val), .serv(serv),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );
endmodule

// File: tb/guard_timer_test.sv
`timescale 1ns/1ps
module guard_timer_test;
  localparam logic [11:0] A_CNT = 12'h000, A_MODE = 12'h008,
                          A_SERV = 12'h00C, A_KEY = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;
  localparam int NV = 21;
  // entry: {write, addr, wdata, expected read}
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, A_KEY,   32'h0,        32'h0},     // R1 unlocked after reset
    {1'b0, A_CNT,   32'h0,        32'h0},     // R10
    {1'b0, A_MODE,  32'h0,        32'h0},     // R10
    {1'b1, A_CNT,   32'h1234,     32'h0},
    {1'b0, A_CNT,   32'h0,        32'h1234},  // R2
    {1'b1, A_MODE,  32'hFFFFFFFE, 32'h0},
    {1'b0, A_MODE,  32'h0,        32'h2},     // R2
    {1'b0, 12'h004, 32'h0,        32'h0},     // R2 unmapped
    {1'b1, A_KEY,   32'h1,        32'h0},
    {1'b0, A_KEY,   32'h0,        32'h1},     // R1 locked
    {1'b1, A_CNT,   32'hDEAD,     32'h0},
    {1'b1, A_MODE,  32'h1,        32'h0},
    {1'b0, A_CNT,   32'h0,        32'h1234},  // R3
    {1'b0, A_MODE,  32'h0,        32'h2},     // R3
    {1'b1, A_KEY,   32'h1ACCE550, 32'h0},
    {1'b0, A_KEY,   32'h0,        32'h1},     // R1 near-key still locks
    {1'b1, A_KEY,   KEY,          32'h0},
    {1'b0, A_KEY,   32'h0,        32'h0},     // R1 unlocked
    {1'b1, A_MODE,  32'h0,        32'h0},
    {1'b0, A_MODE,  32'h0,        32'h0},     // R2
    {1'b1, A_CNT,   32'h0,        32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, sys_rst_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  guard_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  function automatic string vec_tag(int i);
    case (i)
      0, 9, 15, 17: return "R1";
      1, 2:         return "R10";
      12, 13:       return "R3";
      default:      return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0;
    step(2);
    chk("R8 reset low during reset", {31'b0, sys_rst_o}, 32'h0);
    chk("R10 irq low during reset", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    step(3);
  endtask

  initial begin
    do_reset();
    chk("R10 irq after reset", {31'b0, irq_o}, 32'h0);
    chk("R10 sys_rst after reset", {31'b0, sys_rst_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_we = VEC[i][76]; bus_addr = VEC[i][75:64]; bus_wdata = VEC[i][63:32];
      if (!VEC[i][76]) begin
        #1 chk(vec_tag(i), bus_rdata, VEC[i][31:0]);
      end
      @(negedge clk);
    end
    bus_we = 1'b0;

    // R4 / R5: first expiry at 48 cycles, second at 96 (count 2)
    do_reset();
    wr(A_MODE, 32'h3);
    wr(A_CNT, 32'h2);
    step(47); chk("R4 no irq before 48", {31'b0, irq_o}, 32'h0);
    step(1);  chk("R4 irq at 48", {31'b0, irq_o}, 32'h1);
    step(47); chk("R5 no reset before second expiry", {31'b0, sys_rst_o}, 32'h0);
    step(1);  chk("R5 reset at second expiry", {31'b0, sys_rst_o}, 32'h1);
    wr(A_SERV, 32'h0);
    wr(A_MODE, 32'h0);
    step(100); chk("R8 reset held", {31'b0, sys_rst_o}, 32'h1);
    do_reset();
    chk("R8 reset cleared by reset input", {31'b0, sys_rst_o}, 32'h0);

    // R6: service clears and restarts the full interval (count 1 -> 32)
    wr(A_MODE, 32'h3);
    wr(A_CNT, 32'h1);
    step(32); chk("R4 irq at 32", {31'b0, irq_o}, 32'h1);
    wr(A_SERV, 32'hABCD0123);
    chk("R6 irq cleared by service", {31'b0, irq_o}, 32'h0);
    step(31); chk("R6 no irq before full interval", {31'b0, irq_o}, 32'h0);
    step(1);  chk("R6 irq after full interval", {31'b0, irq_o}, 32'h1);
    chk("R6 no reset after service", {31'b0, sys_rst_o}, 32'h0);

    // R7: service sampled on the second-expiry edge (count 0)
    do_reset();
    wr(A_MODE, 32'h3);
    wr(A_CNT, 32'h0);
    step(16); chk("R4 irq at 16 for count 0", {31'b0, irq_o}, 32'h1);
    step(15);
    wr(A_SERV, 32'h0);
    chk("R7 irq clear after collision", {31'b0, irq_o}, 32'h0);
    chk("R7 reset low after collision", {31'b0, sys_rst_o}, 32'h0);
    step(15); chk("R7 no irq before reload interval", {31'b0, irq_o}, 32'h0);
    step(1);  chk("R7 irq after reload interval", {31'b0, irq_o}, 32'h1);

    // R5 reset disabled, R9 stop
    do_reset();
    wr(A_MODE, 32'h1);
    wr(A_CNT, 32'h0);
    step(16); chk("R4 irq run-only mode", {31'b0, irq_o}, 32'h1);
    step(16); chk("R5 no reset when disabled", {31'b0, sys_rst_o}, 32'h0);
    wr(A_MODE, 32'h0);
    chk("R9 irq low when stopped", {31'b0, irq_o}, 32'h0);
    step(64);
    chk("R9 irq stays low", {31'b0, irq_o}, 32'h0);
    chk("R9 no reset while stopped", {31'b0, sys_rst_o}, 32'h0);

    // R3: locked service write does not clear the interrupt
    do_reset();
    wr(A_MODE, 32'h1);
    wr(A_CNT, 32'h0);
    step(16);
    wr(A_KEY, 32'h1);
    wr(A_SERV, 32'h0);
    chk("R3 locked service ignored", {31'b0, irq_o}, 32'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule